// File: doc/BRIEF.md
# Conditional and Relative Branch Evaluator

This block resolves the jump family of an 8-bit accumulator-based processor core in a single registered stage. The decoder hands it an operation class together with every value the instruction needs. These values are the accumulator, an operand that has already been fetched (from a register, a direct byte or an indirect location), an immediate compare constant, an 8-bit signed displacement, the absolute address bits and the address of the instruction that follows the jump. One clock after a valid strobe the block presents its results:

- whether the jump is taken;
- the address to continue from;
- the decremented count with its write strobe, for the decrement-and-jump forms;
- the new carry with its write strobe, for the compare-and-jump forms;
- the number of machine cycles the instruction costs for the outcome it actually took.

Instruction fetch, operand memory access and any branch prediction or target caching live outside this block.

Top module: `cbr_unit`

## Requirements
- R1: `op_class` encoding is 0 no-op, 1 jump-if-acc-zero, 2 jump-if-acc-nonzero, 3 compare acc with operand, 4 compare acc with constant, 5 compare register operand with constant, 6 compare indirect operand with constant, 7 decrement register, 8 decrement direct byte, 9 short relative jump, 10 in-page absolute jump, 11 long absolute jump. Every output is zero during reset. `out_valid` rises exactly one clock after `in_valid` is sampled high. Whenever `in_valid` was low, `taken`, `dec_we` and `cy_we` are low in the following cycle.
- R2: Class 1 is taken only when `acc` is 0x00, and class 2 only when it is not. Both cost 2 cycles when not taken and 3 when taken.
- R3: The compare classes take the branch when their two operands differ. Class 3 compares `acc` with `opnd`, class 4 compares `acc` with `cmp_k`, and classes 5 and 6 compare `opnd` with `cmp_k`. Classes 3 to 5 cost 3 cycles not taken and 4 taken. Class 6 costs 4 and 5.
- R4: For every compare class, `cy_we` is 1 and `cy_out` is 1 exactly when the first operand is unsigned-less-than the second. This holds whether or not the branch is taken.
- R5: Classes 7 and 8 output `dec_val` = `opnd` − 1 modulo 256, so 0x00 becomes 0xFF. They assert `dec_we` and never `cy_we`, and they are taken when `dec_val` is nonzero. Class 7 costs 2 or 3 cycles and class 8 costs 3 or 4.
- R6: A taken relative jump (classes 1 to 9) targets `next_pc` plus the sign-extended `rel`, modulo 65536. Class 9 is always taken and costs 3 cycles.
- R7: Class 10 is always taken and costs 3 cycles. Its target keeps bits 15:11 of `next_pc` and takes bits 10:0 from `abs_addr`.
- R8: Class 11 is always taken, costs 4 cycles and targets all 16 bits of `abs_addr`.
- R9: When a branch is not taken, `target` equals `next_pc`.
- R10: Class 0 and the unused codes 12 to 15 are never taken. They cost 1 cycle, target `next_pc`, and assert neither `dec_we` nor `cy_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_class | input | 4 | Decoded operation class |
| acc | input | 8 | Accumulator value |
| opnd | input | 8 | Fetched register, direct or indirect operand |
| cmp_k | input | 8 | Immediate compare constant |
| rel | input | 8 | Signed relative displacement |
| abs_addr | input | 16 | Absolute target bits |
| next_pc | input | 16 | Address of the following instruction |
| out_valid | output | 1 | Result strobe |
| taken | output | 1 | Branch taken |
| target | output | 16 | Continuation address |
| dec_val | output | 8 | Decremented count |
| dec_we | output | 1 | Write strobe for `dec_val` |
| cy_out | output | 1 | Carry produced by compare |
| cy_we | output | 1 | Write strobe for `cy_out` |
| cycles | output | 3 | Machine cycles for the resolved outcome |

## Verification
The clocked properties assume that `in_valid` stays low while reset is held. Under that assumption the first cycle after reset never carries a request, and the strobe-follow check starts from a known state. They also assume that any of the 16 class codes may arrive, so the no-op rule covers the unused codes as well.

The bench holds `in_valid` low throughout reset. It then drives all 16 codes, with idle cycles placed at random between requests. The directed cases include displacements of −128 and +127 around the address-space ends, and `next_pc` values on either side of a 2K page boundary.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

   typedef enum logic [3:0] {
      OP_NOP   = 4'd0,
      OP_JZ    = 4'd1,
      OP_JNZ   = 4'd2,
      OP_CJ_AD = 4'd3,
      OP_CJ_AI = 4'd4,
      OP_CJ_RI = 4'd5,
      OP_CJ_II = 4'd6,
      OP_DJ_R  = 4'd7,
      OP_DJ_D  = 4'd8,
      OP_SJMP  = 4'd9,
      OP_AJMP  = 4'd10,
      OP_LJMP  = 4'd11
   } op_e;

   typedef enum logic [1:0] {
      TM_FALL = 2'd0,
      TM_REL  = 2'd1,
      TM_PAGE = 2'd2,
      TM_FULL = 2'd3
   } tmode_e;

endpackage

// File: rtl/cbr_eval.sv
module cbr_eval
   import cbr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CYC_W  = 3
) (
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [DATA_W-1:0] cmp_i,
   output logic              take_o,
   output logic [DATA_W-1:0] dec_o,
   output logic              dec_we_o,
   output logic              cy_o,
   output logic              cy_we_o,
   output logic [CYC_W-1:0]  cyc_o,
   output tmode_e            tmode_o
);

   localparam int MAX_CYC = 5;

   generate
      if ((1 << CYC_W) <= MAX_CYC) begin : g_bad_cyc
         $error("cbr_eval: CYC_W too narrow for cycle counts");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("cbr_eval: DATA_W must be positive");
      end
   endgenerate

   op_e               op;
   logic [DATA_W-1:0] lhs, rhs;
   logic              differ, below;
   logic [CYC_W-1:0]  base;
   tmode_e            tm_take;

   assign op     = op_e'(op_i);
   assign dec_o  = opnd_i - {{(DATA_W-1){1'b0}}, 1'b1};

   always_comb begin
      lhs = ((op == OP_CJ_AD) || (op == OP_CJ_AI)) ? acc_i : opnd_i;
      rhs = (op == OP_CJ_AD) ? opnd_i : cmp_i;
   end

   assign differ = (lhs != rhs);
   assign below  = (lhs < rhs);

   always_comb begin
      take_o   = 1'b0;
      dec_we_o = 1'b0;
      cy_we_o  = 1'b0;
      cy_o     = 1'b0;
      base     = CYC_W'(1);
      tm_take  = TM_REL;
      case (op)
         OP_JZ: begin
            take_o = (acc_i == '0);
            base   = CYC_W'(2);
         end
         OP_JNZ: begin
            take_o = (acc_i != '0);
            base   = CYC_W'(2);
         end
         OP_CJ_AD, OP_CJ_AI, OP_CJ_RI: begin
            take_o  = differ;
            cy_we_o = 1'b1;
            cy_o    = below;
            base    = CYC_W'(3);
         end
         OP_CJ_II: begin
            take_o  = differ;
            cy_we_o = 1'b1;
            cy_o    = below;
            base    = CYC_W'(4);
         end
         OP_DJ_R: begin
            take_o   = (dec_o != '0);
            dec_we_o = 1'b1;
            base     = CYC_W'(2);
         end
         OP_DJ_D: begin
            take_o   = (dec_o != '0);
            dec_we_o = 1'b1;
            base     = CYC_W'(3);
         end
         OP_SJMP: begin
            take_o = 1'b1;
            base   = CYC_W'(2);
         end
         OP_AJMP: begin
            take_o  = 1'b1;
            base    = CYC_W'(2);
            tm_take = TM_PAGE;
         end
         OP_LJMP: begin
            take_o  = 1'b1;
            base    = CYC_W'(3);
            tm_take = TM_FULL;
         end
         default: begin
            take_o = 1'b0;
            base   = CYC_W'(1);
         end
      endcase
   end

   assign cyc_o   = base + {{(CYC_W-1){1'b0}}, take_o};
   assign tmode_o = take_o ? tm_take : TM_FALL;

endmodule

// File: rtl/cbr_target.sv
module cbr_target
   import cbr_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int PAGE_W = 11,
   parameter int REL_W  = 8
) (
   input  logic [ADDR_W-1:0] npc_i,
   input  logic [REL_W-1:0]  rel_i,
   input  logic [ADDR_W-1:0] abs_i,
   input  tmode_e            mode_i,
   output logic [ADDR_W-1:0] tgt_o
);

   localparam int EXT_W = ADDR_W - REL_W;

   generate
      if (REL_W >= ADDR_W) begin : g_bad_rel
         $error("cbr_target: REL_W must be narrower than ADDR_W");
      end
      if (PAGE_W > ADDR_W) begin : g_bad_page
         $error("cbr_target: PAGE_W must not exceed ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] rel_sum;
   logic [ADDR_W-1:0] page_tgt;

   assign rel_sum = npc_i + {{EXT_W{rel_i[REL_W-1]}}, rel_i};

   generate
      if (PAGE_W < ADDR_W) begin : g_page_splice
         assign page_tgt = {npc_i[ADDR_W-1:PAGE_W], abs_i[PAGE_W-1:0]};
      end else begin : g_page_whole
         assign page_tgt = abs_i;
      end
   endgenerate

   always_comb begin
      case (mode_i)
         TM_REL:  tgt_o = rel_sum;
         TM_PAGE: tgt_o = page_tgt;
         TM_FULL: tgt_o = abs_i;
         default: tgt_o = npc_i;
      endcase
   end

endmodule

// File: rtl/cbr_unit.sv
module cbr_unit
   import cbr_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int REL_W  = 8,
   parameter int PAGE_W = 11,
   parameter int CYC_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        op_class,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] opnd,
   input  logic [DATA_W-1:0] cmp_k,
   input  logic [REL_W-1:0]  rel,
   input  logic [ADDR_W-1:0] abs_addr,
   input  logic [ADDR_W-1:0] next_pc,
   output logic              out_valid,
   output logic              taken,
   output logic [ADDR_W-1:0] target,
   output logic [DATA_W-1:0] dec_val,
   output logic              dec_we,
   output logic              cy_out,
   output logic              cy_we,
   output logic [CYC_W-1:0]  cycles
);

   logic              e_take, e_dec_we, e_cy, e_cy_we;
   logic [DATA_W-1:0] e_dec;
   logic [CYC_W-1:0]  e_cyc;
   tmode_e            e_tm;
   logic [ADDR_W-1:0] e_tgt;

   cbr_eval #(.DATA_W(DATA_W), .CYC_W(CYC_W)) u_eval (
      .op_i     (op_class),
      .acc_i    (acc),
      .opnd_i   (opnd),
      .cmp_i    (cmp_k),
      .take_o   (e_take),
      .dec_o    (e_dec),
      .dec_we_o (e_dec_we),
      .cy_o     (e_cy),
      .cy_we_o  (e_cy_we),
      .cyc_o    (e_cyc),
      .tmode_o  (e_tm)
   );

   cbr_target #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .REL_W(REL_W)) u_tgt (
      .npc_i  (next_pc),
      .rel_i  (rel),
      .abs_i  (abs_addr),
      .mode_i (e_tm),
      .tgt_o  (e_tgt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         taken     <= 1'b0;
         target    <= '0;
         dec_val   <= '0;
         dec_we    <= 1'b0;
         cy_out    <= 1'b0;
         cy_we     <= 1'b0;
         cycles    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            taken   <= e_take;
            target  <= e_tgt;
            dec_val <= e_dec;
            dec_we  <= e_dec_we;
            cy_out  <= e_cy;
            cy_we   <= e_cy_we;
            cycles  <= e_cyc;
         end else begin
            taken  <= 1'b0;
            dec_we <= 1'b0;
            cy_we  <= 1'b0;
         end
      end
   end

   AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid) else $error("valid lag"); // R1
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !taken && !dec_we && !cy_we)) else $error("idle quiet"); // R1
   AST_TAKEN_COST: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && taken) |-> (cycles >= CYC_W'(3))) else $error("taken cost"); // R2
   AST_DJNZ_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      dec_we |-> (taken == (dec_val != '0))) else $error("djnz take"); // R5
   AST_WRITE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec_we && cy_we)) else $error("write excl"); // R5
   AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_class == OP_AJMP) |=>
         (target[ADDR_W-1:PAGE_W] == $past(next_pc[ADDR_W-1:PAGE_W]))) else $error("page keep"); // R7
   AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (taken || target == $past(next_pc))) else $error("fall through"); // R9
   AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op_class == OP_NOP || op_class > OP_LJMP)) |=>
         (!taken && cycles == CYC_W'(1))) else $error("nop quiet"); // R10

endmodule

// File: tb/cbr_unit_bench.sv
module cbr_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  op_class = '0;
   logic [7:0]  acc = '0, opnd = '0, cmp_k = '0, rel = '0;
   logic [15:0] abs_addr = '0, next_pc = '0;
   logic        out_valid, taken, dec_we, cy_out, cy_we;
   logic [15:0] target;
   logic [7:0]  dec_val;
   logic [2:0]  cycles;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   cbr_unit u_cbr_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_class(op_class),
      .acc(acc), .opnd(opnd), .cmp_k(cmp_k), .rel(rel), .abs_addr(abs_addr),
      .next_pc(next_pc), .out_valid(out_valid), .taken(taken), .target(target),
      .dec_val(dec_val), .dec_we(dec_we), .cy_out(cy_out), .cy_we(cy_we),
      .cycles(cycles)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input int op);
      case (op)
         1, 2:       return "R2";
         3, 4, 5, 6: return "R3";
         7, 8:       return "R5";
         9:          return "R6";
         10:         return "R7";
         11:         return "R8";
         default:    return "R10";
      endcase
   endfunction

   // behavioural reference model
   task automatic model(input int op, a, o, k, r, ab, np,
                        output int tk, tg, dv, dwe, cy, cwe, cyc);
      int l, rr, disp;
      tk = 0; dv = 0; dwe = 0; cy = 0; cwe = 0; cyc = 1;
      disp = (r >= 128) ? r - 256 : r;
      tg = np;
      if (op >= 3 && op <= 6) begin
         l  = (op <= 4) ? a : o;
         rr = (op == 3) ? o : k;
         tk = (l != rr);
         cy = (l < rr);
         cwe = 1;
         cyc = ((op == 6) ? 4 : 3) + tk;
      end else if (op == 1 || op == 2) begin
         tk  = (op == 1) ? (a == 0) : (a != 0);
         cyc = 2 + tk;
      end else if (op == 7 || op == 8) begin
         dv  = (o + 255) % 256;
         dwe = 1;
         tk  = (dv != 0);
         cyc = ((op == 7) ? 2 : 3) + tk;
      end else if (op == 9) begin
         tk = 1; cyc = 3;
      end else if (op == 10) begin
         tk = 1; cyc = 3; tg = (np & 16'hF800) | (ab & 16'h07FF);
      end else if (op == 11) begin
         tk = 1; cyc = 4; tg = ab;
      end
      if (tk && op <= 9) tg = (np + disp + 65536) % 65536;
   endtask

   task automatic apply(input int op, a, o, k, r, ab, np);
      int tk, tg, dv, dwe, cy, cwe, cyc;
      string t;
      model(op, a, o, k, r, ab, np, tk, tg, dv, dwe, cy, cwe, cyc);
      op_class = op[3:0]; acc = a[7:0]; opnd = o[7:0]; cmp_k = k[7:0];
      rel = r[7:0]; abs_addr = ab[15:0]; next_pc = np[15:0]; in_valid = 1'b1;
      @(negedge clk);
      t = tag_of(op);
      chk(out_valid == 1'b1, "R1", "out_valid", out_valid, 1);
      chk(taken == tk[0], t, "taken", taken, tk);
      chk(int'(target) == tg, tk ? t : "R9", "target", target, tg);
      chk(int'(cycles) == cyc, t, "cycles", cycles, cyc);
      chk(dec_we == dwe[0], (op == 7 || op == 8) ? "R5" : "R10", "dec_we", dec_we, dwe);
      chk(cy_we == cwe[0], cwe ? "R4" : "R10", "cy_we", cy_we, cwe);
      if (dwe) chk(int'(dec_val) == dv, "R5", "dec_val", dec_val, dv);
      if (cwe) chk(cy_out == cy[0], "R4", "cy_out", cy_out, cy);
   endtask

   task automatic idle();
      in_valid = 1'b0;
      op_class = 4'($urandom_range(0, 15));
      @(negedge clk);
      chk(!out_valid && !taken && !dec_we && !cy_we, "R1", "idle strobes",
          {out_valid, taken, dec_we, cy_we}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk({out_valid, taken, dec_we, cy_we} == 0 && target == 0 && cycles == 0,
          "R1", "reset state", {out_valid, taken, target}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 zero tests
      apply(1, 0, 0, 0, 8'h10, 0, 16'h1234);
      apply(1, 5, 0, 0, 8'h10, 0, 16'h1234);
      apply(2, 0, 0, 0, 8'hF0, 0, 16'h1234);
      apply(2, 8'hFF, 0, 0, 8'hF0, 0, 16'h1234);
      // R3 / R4 compare forms
      apply(3, 8'h20, 8'h20, 0, 8'h05, 0, 16'h0100);
      apply(3, 8'h10, 8'h20, 0, 8'h05, 0, 16'h0100);
      apply(4, 8'h30, 0, 8'h20, 8'h05, 0, 16'h0100);
      apply(5, 0, 8'h00, 8'hFF, 8'h05, 0, 16'h0100);
      apply(5, 0, 8'h44, 8'h44, 8'h05, 0, 16'h0100);
      apply(6, 0, 8'hFF, 8'h00, 8'h05, 0, 16'h0100);
      apply(6, 0, 8'h07, 8'h07, 8'h05, 0, 16'h0100);
      // R5 decrement wrap and zero
      apply(7, 0, 8'h01, 0, 8'hFE, 0, 16'h0200);
      apply(7, 0, 8'h00, 0, 8'hFE, 0, 16'h0200);
      apply(8, 0, 8'h01, 0, 8'h02, 0, 16'h0200);
      apply(8, 0, 8'h80, 0, 8'h02, 0, 16'h0200);
      // R6 displacement extremes and address wrap
      apply(9, 0, 0, 0, 8'h80, 0, 16'h0010);
      apply(9, 0, 0, 0, 8'h7F, 0, 16'hFFF0);
      apply(9, 0, 0, 0, 8'h80, 0, 16'h8000);
      apply(9, 0, 0, 0, 8'h7F, 0, 16'h7FFF);
      // R7 page boundary
      apply(10, 0, 0, 0, 0, 16'hFFFF, 16'h07FF);
      apply(10, 0, 0, 0, 0, 16'h0123, 16'h0800);
      apply(10, 0, 0, 0, 0, 16'h0000, 16'hFFFF);
      // R8 long jump
      apply(11, 0, 0, 0, 0, 16'hABCD, 16'h0003);
      // R10 no-op and unused codes
      for (int c = 12; c < 16; c++) apply(c, 0, 0, 0, 8'h40, 16'h5555, 16'h4444);
      apply(0, 0, 0, 0, 8'h40, 16'h5555, 16'h4444);
      idle();
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(0, 4) == 0) idle();
         apply(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
               int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
               int'($urandom_range(0, 255)), int'($urandom_range(0, 65535)),
               int'($urandom_range(0, 65535)));
      end
      idle();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule